// File: doc/BRIEF.md
# Masked Interrupt Event Router

This block keeps the interrupt event flags of an Ethernet MAC and the mask that gates them, and drives thirteen separate interrupt wires, one per defined event. Internal sources such as the transmit and receive engines report an event by raising a one-cycle pulse on the set input that belongs to its line. Software reads the flags and the mask over a single-cycle register port. It acknowledges an event by writing a one to its flag bit, and it loads the mask by writing it whole.

Two of the port's registers raise events themselves. Any write to the management-frame register raises the management-done event. A write to the transmit-control register with its stop-request bit set raises the graceful-stop event at once. A write to the control register with its reset bit set clears the flags, the mask, the control value and the transmit-control value. The interrupt wires are registered, so each one follows the flag and mask state of the previous clock edge.

Top module: `irq_event_router`

## Requirements
- R1: After rst_n is released, every register in this list reads zero and all thirteen irq_line bits are low: event (0x004), mask (0x008), control (0x024), management-frame (0x040) and transmit-control (0x0C4).
- R2: A one-cycle pulse on hw_set[i] sets one event bit, shown at read offset 0x004 after the next clock edge. Lines 0 to 12 map to event bit positions 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30 in that order.
- R3: A write to offset 0x004 clears each event bit written as one and leaves each bit written as zero unchanged.
- R4: A write to offset 0x008 replaces all 32 mask bits, and offset 0x008 reads back the written value.
- R5: irq_line[i] is high exactly when the event bit of line i (positions as in R2) and the mask bit at the same position were both set at the previous clock edge. The line changes one clock edge after the register change.
- R6: Any write to offset 0x040 sets event bit 23, whatever the data. The written value reads back at 0x040.
- R7: A write to offset 0x0C4 with data bit 0 set sets event bit 28. With data bit 0 clear it sets nothing. The written value reads back at 0x0C4.
- R8: A write to offset 0x024 with data bit 0 set clears the event, mask, control and transmit-control registers, and a set pulse in that same cycle is dropped. With data bit 0 clear, the value is stored and reads back, and no register is cleared.
- R9: When a set pulse and a software clear target the same event bit in the same cycle, the bit ends up set.
- R10: Event bits 18 to 0 always read zero.
- R11: Reads of any other offset return zero, and writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 10 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| hw_set | input | 13 | One-cycle event set pulses, indexed by line number |
| irq_line | output | 13 | Registered per-event interrupt lines |

## Verification
The assertions assume that a register write lasts exactly one cycle and that the address and data are stable while reg_wr is high. They also assume that hw_set carries pulses, not levels that the checks could mistake for repeated events. The bench drives every input on the falling clock edge, drops reg_wr after one cycle, and holds each hw_set bit for a single cycle. It samples outputs on the next falling edge, so each expected value falls in the cycle that the requirements name.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 10;
  localparam int NLINES  = 13;
  localparam int EVT_LO  = 19;

  localparam int BIT_MII = 23;
  localparam int BIT_GRA = 28;

  localparam logic [ADDR_W-1:0] OFS_EVENT = 10'h004;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 10'h008;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 10'h024;
  localparam logic [ADDR_W-1:0] OFS_MGMT  = 10'h040;
  localparam logic [ADDR_W-1:0] OFS_TXCTL = 10'h0C4;

  localparam int CTRL_RST_BIT = 0;
  localparam int TXC_STOP_BIT = 0;

  // Bits of the event word that can hold a flag.
  localparam logic [DATA_W-1:0] EVT_STORABLE = ~((DATA_W'(1) << EVT_LO) - DATA_W'(1));

  // Fixed routing: output line number to event bit position.
  function automatic int line_bit(input int idx);
    case (idx)
      0:  return 27;
      1:  return 26;
      2:  return 19;
      3:  return 20;
      4:  return 25;
      5:  return 24;
      6:  return 23;
      7:  return 21;
      8:  return 31;
      9:  return 28;
      10: return 22;
      11: return 29;
      default: return 30;
    endcase
  endfunction

  // Place line-indexed pulses at their event bit positions.
  function automatic logic [DATA_W-1:0] scatter(input logic [NLINES-1:0] lines);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int i = 0; i < NLINES; i++) v[line_bit(i)] = lines[i];
    return v;
  endfunction

  // Pick event-word bits back into line order.
  function automatic logic [NLINES-1:0] gather(input logic [DATA_W-1:0] v);
    logic [NLINES-1:0] l;
    for (int i = 0; i < NLINES; i++) l[i] = v[line_bit(i)];
    return l;
  endfunction

  // Next event word: clear-by-one first, then sets win.
  function automatic logic [DATA_W-1:0] evt_next(input logic [DATA_W-1:0] cur,
                                                 input logic [DATA_W-1:0] clr,
                                                 input logic [DATA_W-1:0] set);
    return ((cur & ~clr) | set) & EVT_STORABLE;
  endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_router_pkg::*;
(
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              wr_event,
  output logic              wr_mask,
  output logic              wr_ctrl,
  output logic              wr_mgmt,
  output logic              wr_txctl,
  output logic              soft_rst,
  output logic              trig_mii,
  output logic              trig_gra
);

  always_comb begin
    wr_event = reg_wr && (reg_addr == OFS_EVENT);
    wr_mask  = reg_wr && (reg_addr == OFS_MASK);
    wr_ctrl  = reg_wr && (reg_addr == OFS_CTRL);
    wr_mgmt  = reg_wr && (reg_addr == OFS_MGMT);
    wr_txctl = reg_wr && (reg_addr == OFS_TXCTL);
    soft_rst = wr_ctrl && reg_wdata[CTRL_RST_BIT];
    trig_mii = wr_mgmt;
    trig_gra = wr_txctl && reg_wdata[TXC_STOP_BIT];
  end

endmodule

// File: rtl/irq_event_store.sv
module irq_event_store
  import irq_router_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] clr_bits,
  input  logic [DATA_W-1:0] set_vec,
  output logic [DATA_W-1:0] ev_q
);

  logic [DATA_W-1:0] clr_eff;
  logic [DATA_W-1:0] ev_d;

  always_comb begin
    clr_eff = clr_we ? clr_bits : '0;
    ev_d    = soft_rst ? '0 : evt_next(ev_q, clr_eff, set_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= ev_d;
  end

endmodule

// File: rtl/irq_line_drive.sv
module irq_line_drive
  import irq_router_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ev_q,
  input  logic [DATA_W-1:0] mask_q,
  output logic [NLINES-1:0] irq_line
);

  logic [DATA_W-1:0] active;
  assign active = ev_q & mask_q;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    localparam int POS = line_bit(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_line[g] <= 1'b0;
      else        irq_line[g] <= active[POS];
    end
  end

endmodule

// File: rtl/irq_event_router.sv
module irq_event_router
  import irq_router_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NLINES-1:0] hw_set,
  output logic [NLINES-1:0] irq_line
);

  logic wr_event, wr_mask, wr_ctrl, wr_mgmt, wr_txctl;
  logic soft_rst, trig_mii, trig_gra;

  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] ev_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] mgmt_q;
  logic [DATA_W-1:0] txctl_q;

  irq_reg_decode u_dec (
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .wr_event  (wr_event),
    .wr_mask   (wr_mask),
    .wr_ctrl   (wr_ctrl),
    .wr_mgmt   (wr_mgmt),
    .wr_txctl  (wr_txctl),
    .soft_rst  (soft_rst),
    .trig_mii  (trig_mii),
    .trig_gra  (trig_gra)
  );

  always_comb begin
    set_vec = scatter(hw_set);
    set_vec[BIT_MII] = set_vec[BIT_MII] | trig_mii;
    set_vec[BIT_GRA] = set_vec[BIT_GRA] | trig_gra;
  end

  irq_event_store u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .clr_we   (wr_event),
    .clr_bits (reg_wdata),
    .set_vec  (set_vec),
    .ev_q     (ev_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      ctrl_q  <= '0;
      mgmt_q  <= '0;
      txctl_q <= '0;
    end else begin
      if (soft_rst) begin
        mask_q  <= '0;
        ctrl_q  <= '0;
        txctl_q <= '0;
      end else begin
        if (wr_mask)  mask_q  <= reg_wdata;
        if (wr_ctrl)  ctrl_q  <= reg_wdata;
        if (wr_txctl) txctl_q <= reg_wdata;
      end
      if (wr_mgmt) mgmt_q <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_EVENT: reg_rdata = ev_q;
      OFS_MASK:  reg_rdata = mask_q;
      OFS_CTRL:  reg_rdata = ctrl_q;
      OFS_MGMT:  reg_rdata = mgmt_q;
      OFS_TXCTL: reg_rdata = txctl_q;
      default:   reg_rdata = '0;
    endcase
  end

  irq_line_drive u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_q     (ev_q),
    .mask_q   (mask_q),
    .irq_line (irq_line)
  );

endmodule

// File: rtl/irq_event_router_chk.sv
module irq_event_router_chk
  import irq_router_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] ev_q,
  input logic [DATA_W-1:0] mask_q,
  input logic [DATA_W-1:0] set_vec,
  input logic              soft_rst,
  input logic              trig_mii,
  input logic [NLINES-1:0] irq_line
);

  // R5: lines follow last edge's masked events through the fixed routing
  assert_line_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_line == gather($past(ev_q) & $past(mask_q)));

  // R9: a set request is never lost unless a soft reset takes the cycle
  assert_set_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec != '0) && !soft_rst) |=> ((ev_q & $past(set_vec)) == $past(set_vec)));

  // R3: a flag only rises when a set request was present
  assert_no_spurious_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q & ~$past(ev_q) & ~$past(set_vec)) == '0);

  // R10: low event bits never hold a flag
  assert_low_bits_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_q[EVT_LO-1:0] == '0);

  // R8: soft reset leaves events and mask cleared
  assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ev_q == '0) && (mask_q == '0));

  // R6: management write raises the management event
  assert_mgmt_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_mii |=> ev_q[BIT_MII]);

endmodule

bind irq_event_router irq_event_router_chk u_chk (.*);

// File: tb/sim_irq_event_router.sv
`timescale 1ns/1ps
module sim_irq_event_router;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [12:0] hw_set = '0;
  logic [12:0] irq_line;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int pos [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

  always #2.5 clk = ~clk;

  irq_event_router u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_set(hw_set),
    .irq_line(irq_line)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input int line);
    hw_set = 13'(1) << line;
    @(negedge clk);
    hw_set = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(10'h004, d); chk("R1 event", d, 0);
    rd(10'h008, d); chk("R1 mask", d, 0);
    rd(10'h024, d); chk("R1 ctrl", d, 0);
    rd(10'h040, d); chk("R1 mgmt", d, 0);
    rd(10'h0C4, d); chk("R1 txctl", d, 0);
    chk("R1 lines", 32'(irq_line), 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(10'h008, 32'hFFFF_FFFF);
    rd(10'h008, d); chk("R4 mask readback", d, 32'hFFFF_FFFF);
    for (int i = 0; i < 13; i++) begin
      pulse(i);
      rd(10'h004, d); chk("R2 event bit for line", d, 32'(1) << pos[i]);
      chk("R10 low bits", 32'(d[18:0]), 0);
      @(negedge clk);
      chk("R5 line routed", 32'(irq_line), 32'(1) << i);
      wr(10'h004, 32'(1) << pos[i]);
      rd(10'h004, d); chk("R3 clear", d, 0);
      @(negedge clk);
      chk("R5 line drops", 32'(irq_line), 0);
    end
  endtask

  task automatic t_w1c_mask();
    logic [31:0] d;
    pulse(0); pulse(4); pulse(8);
    rd(10'h004, d); chk("R2 three events", d, 32'h8A00_0000);
    wr(10'h004, 32'h0200_0000);
    rd(10'h004, d); chk("R3 zeros keep bits", d, 32'h8800_0000);
    wr(10'h008, 32'h0800_0000);
    @(negedge clk);
    chk("R5 masked lines", 32'(irq_line), 32'h1);
    wr(10'h008, 32'h0);
    @(negedge clk);
    chk("R5 mask off", 32'(irq_line), 0);
    wr(10'h004, 32'hFFFF_FFFF);
    rd(10'h004, d); chk("R3 clear all", d, 0);
  endtask

  task automatic t_triggers();
    logic [31:0] d;
    wr(10'h040, 32'h0);
    rd(10'h004, d); chk("R6 mgmt event", d, 32'h0080_0000);
    wr(10'h040, 32'h1234_5678);
    rd(10'h040, d); chk("R6 mgmt readback", d, 32'h1234_5678);
    wr(10'h004, 32'hFFFF_FFFF);
    wr(10'h0C4, 32'h2);
    rd(10'h004, d); chk("R7 no stop event", d, 0);
    rd(10'h0C4, d); chk("R7 txctl readback", d, 32'h2);
    wr(10'h0C4, 32'h5);
    rd(10'h004, d); chk("R7 stop event", d, 32'h1000_0000);
    rd(10'h0C4, d); chk("R7 txctl value", d, 32'h5);
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    wr(10'h008, 32'hF0F0_0000);
    pulse(1);
    wr(10'h024, 32'h6);
    rd(10'h024, d); chk("R8 ctrl stored", d, 32'h6);
    rd(10'h004, d); chk("R8 no clear", d, 32'h1400_0000);
    reg_wr = 1'b1; reg_addr = 10'h024; reg_wdata = 32'h3; hw_set = 13'h1;
    @(negedge clk);
    reg_wr = 1'b0; hw_set = '0;
    rd(10'h004, d); chk("R8 events cleared", d, 0);
    rd(10'h008, d); chk("R8 mask cleared", d, 0);
    rd(10'h024, d); chk("R8 ctrl cleared", d, 0);
    rd(10'h0C4, d); chk("R8 txctl cleared", d, 0);
    rd(10'h040, d); chk("R8 mgmt kept", d, 32'h1234_5678);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    reg_wr = 1'b1; reg_addr = 10'h004; reg_wdata = 32'hFFFF_FFFF; hw_set = 13'h1;
    @(negedge clk);
    reg_wr = 1'b0; hw_set = '0;
    rd(10'h004, d); chk("R9 set wins", d, 32'h0800_0000);
    wr(10'h004, 32'h0800_0000);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(10'h008, 32'h0000_00A5);
    pulse(2);
    wr(10'h00C, 32'hFFFF_FFFF);
    wr(10'h100, 32'hFFFF_FFFF);
    rd(10'h00C, d); chk("R11 read zero", d, 0);
    rd(10'h3FC, d); chk("R11 read zero high", d, 0);
    rd(10'h008, d); chk("R11 mask untouched", d, 32'h0000_00A5);
    rd(10'h004, d); chk("R11 events untouched", d, 32'h0008_0000);
    wr(10'h004, 32'h0000_0001);
    rd(10'h004, d); chk("R10 low write no effect", d, 32'h0008_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_w1c_mask();
    t_triggers();
    t_soft_reset();
    t_collision();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule